// File: doc/BRIEF.md
# Branch Fetch Redirect Controller

This block steers instruction fetch around conditional branches in a five-stage in-order pipeline whose stages are fetch, decode, operand fetch, execute and write-back. It owns the fetch address register. Each cycle it chooses the next fetch address, says whether fetch advances, and names the younger stages whose instruction must be turned into a bubble.

It applies one of four run-time selectable policies to a branch. Freeze stalls fetch until the outcome is known. Predict-untaken keeps fetching sequentially. Predict-taken jumps to the target as soon as decode produces it. Delayed-branch always executes the one instruction that follows the branch. The decode stage reports a branch together with its computed target. The execute stage, two cycles later, reports the taken or untaken outcome. An external incrementer supplies the sequential successor of the current fetch address.

After each branch completes, the block publishes the number of fetch slots that the branch cost. It also flags a branch that sits in a delay slot, which delayed-branch mode forbids.

Top module: `branch_fetch_ctrl`

## Requirements
- R1: While reset is held, fetchPc equals RESET_PC, fetchEn is 1, killMask is 0, slotFault is 0, lastPenalty is 0 and activePolicy is 0 (freeze). Policy codes are 0 freeze, 1 predict-untaken, 2 predict-taken and 3 delayed-branch. killMask bit 0 kills the fetch stage, bit 1 kills decode and bit 2 kills operand fetch.
- R2: With no branch in flight, fetchEn is 1, killMask is 0, nextPc equals seqPc, and fetchPc takes nextPc at each clock edge.
- R3: Freeze: from the decode cycle through the cycle before resolution, fetchEn is 0 and killMask is 001. In the resolution cycle killMask is 001, fetchEn is 1 and nextPc is the target if the branch is taken, or the held fall-through address if it is not. The penalty equals the number of cycles from decode to resolution, inclusive.
- R4: Predict-untaken: decode changes nothing. A taken resolution gives killMask 111 with nextPc equal to the target (penalty 3). An untaken one gives killMask 000 with sequential fetch (penalty 0).
- R5: Predict-taken: in the decode cycle killMask is 001 and nextPc is the decoded target. A taken resolution kills nothing (penalty 1). An untaken one gives killMask 011 with nextPc equal to the fall-through address, which is the fetch address in the decode cycle (penalty 3).
- R6: Delayed-branch: the delay-slot instruction is never killed. A taken resolution gives killMask 011 with nextPc equal to the target (penalty 2). An untaken one kills nothing (penalty 0).
- R7: In delayed-branch mode, a branch decoded in the cycle right after an accepted branch raises slotFault for that cycle. It is not acted on, and the first branch still redirects to its own target.
- R8: Outside that slot case, a branch decoded while another is unresolved raises no flag and has no effect on the redirect.
- R9: policySel is taken into activePolicy only in a cycle with no branch in flight and none being decoded. A change made while a branch is unresolved does not affect that branch, and it is applied once the controller is idle.
- R10: lastPenalty updates at the clock edge that ends the resolution cycle, becoming the penalty of that branch (saturating at its width). It holds at every other edge.
- R11: A resolution strobe with no branch in flight is ignored: no kill, sequential nextPc, and lastPenalty unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| policySel | input | 2 | Requested branch policy (0 freeze, 1 untaken, 2 taken, 3 delayed) |
| brDecoded | input | 1 | Decode stage holds a branch this cycle |
| brTarget | input | PCW | Target computed in decode |
| brResolved | input | 1 | Execute stage resolves the in-flight branch this cycle |
| brTaken | input | 1 | Resolved outcome, 1 means taken |
| seqPc | input | PCW | Sequential successor of fetchPc |
| fetchPc | output | PCW | Address fetched this cycle |
| nextPc | output | PCW | Address loaded into fetchPc when fetchEn is 1 |
| fetchEn | output | 1 | Fetch advances at the coming edge |
| killMask | output | 3 | Bubble strobes for fetch, decode and operand-fetch stages |
| slotFault | output | 1 | Branch found in a delay slot |
| activePolicy | output | 2 | Policy currently applied |
| lastPenalty | output | PENW | Fetch slots lost by the last resolved branch |

## Verification
The bench builds the block with a 16-bit fetch address, a 6-bit penalty field and a reset address of 0x100. With these settings, every combination of the four policies and both outcomes can be swept against several targets, including one near the top of the address space, where target-path sequential fetch wraps to zero. Expected kill masks, redirect addresses and penalties come from a small arithmetic table of each policy. A freeze branch that resolves late, a forbidden delay-slot branch, a second decoded branch, a mid-flight policy change and a stray resolution strobe are run as directed cases.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  typedef enum logic [1:0] {
    POL_FREEZE  = 2'd0,
    POL_UNTAKEN = 2'd1,
    POL_TAKEN   = 2'd2,
    POL_DELAYED = 2'd3
  } policy_e;

  typedef enum logic [2:0] {
    PC_SEQ,
    PC_HOLD,
    PC_TGT_NOW,
    PC_TGT_SAVED,
    PC_FALL
  } pc_sel_e;

  localparam int KILL_W  = 3;
  localparam int KILL_FI = 0;
  localparam int KILL_DI = 1;
  localparam int KILL_FO = 2;

  typedef struct packed {
    logic              fetchEn;
    pc_sel_e           pcSel;
    logic [KILL_W-1:0] killMask;
    logic              capture;
    logic              tally;
    logic              commit;
  } ctl_strobe_t;

endpackage

// File: rtl/bfc_control.sv
module bfc_control
  import bfc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  policySel,
  input  logic        brDecoded,
  input  logic        brResolved,
  input  logic        brTaken,
  output ctl_strobe_t ctl,
  output logic        slotFault,
  output logic        busy,
  output logic [1:0]  activePolicy
);

  localparam int AGE_W = 2;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [KILL_W-1:0] MASK_FI    = KILL_W'(1) << KILL_FI;
  localparam logic [KILL_W-1:0] MASK_YOUNG = MASK_FI | (KILL_W'(1) << KILL_DI);
  localparam logic [KILL_W-1:0] MASK_ALL   = MASK_YOUNG | (KILL_W'(1) << KILL_FO);

  policy_e          policyQ;
  logic             busyQ;
  logic [AGE_W-1:0] ageQ;
  logic             accept;
  logic             resolve;

  assign accept  = !busyQ && brDecoded;
  assign resolve = busyQ && brResolved;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      policyQ <= POL_FREEZE;
      busyQ   <= 1'b0;
      ageQ    <= '0;
    end else begin
      if (!busyQ && !brDecoded) policyQ <= policy_e'(policySel);
      if (accept) begin
        busyQ <= 1'b1;
        ageQ  <= AGE_W'(1);
      end else if (resolve) begin
        busyQ <= 1'b0;
        ageQ  <= '0;
      end else if (busyQ && ageQ != AGE_MAX) begin
        ageQ <= ageQ + AGE_W'(1);
      end
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.fetchEn = 1'b1;
    ctl.pcSel   = PC_SEQ;
    ctl.capture = accept;
    ctl.tally   = busyQ;
    ctl.commit  = resolve;
    slotFault   = 1'b0;
    if (accept) begin
      unique case (policyQ)
        POL_FREEZE: begin
          ctl.fetchEn  = 1'b0;
          ctl.killMask = MASK_FI;
        end
        POL_TAKEN: begin
          ctl.killMask = MASK_FI;
          ctl.pcSel    = PC_TGT_NOW;
        end
        default: ;
      endcase
    end else if (resolve) begin
      unique case (policyQ)
        POL_FREEZE: begin
          ctl.killMask = MASK_FI;
          ctl.pcSel    = brTaken ? PC_TGT_SAVED : PC_HOLD;
        end
        POL_UNTAKEN: begin
          if (brTaken) begin
            ctl.killMask = MASK_ALL;
            ctl.pcSel    = PC_TGT_SAVED;
          end
        end
        POL_TAKEN: begin
          if (!brTaken) begin
            ctl.killMask = MASK_YOUNG;
            ctl.pcSel    = PC_FALL;
          end
        end
        POL_DELAYED: begin
          if (brTaken) begin
            ctl.killMask = MASK_YOUNG;
            ctl.pcSel    = PC_TGT_SAVED;
          end
        end
        default: ;
      endcase
    end else if (busyQ) begin
      if (policyQ == POL_FREEZE) begin
        ctl.fetchEn  = 1'b0;
        ctl.killMask = MASK_FI;
      end
      if (policyQ == POL_DELAYED && ageQ == AGE_W'(1) && brDecoded) slotFault = 1'b1;
    end
  end

  assign busy         = busyQ;
  assign activePolicy = policyQ;

  // R7: a slot fault can only follow an accepted delayed-mode branch by one cycle
  p_slot_fault_age_r7: assert property (@(posedge clk) disable iff (!rstN)
    slotFault |-> (busyQ && policyQ == POL_DELAYED && $past(accept)));

endmodule

// File: rtl/bfc_datapath.sv
module bfc_datapath
  import bfc_pkg::*;
#(
  parameter int PCW      = 32,
  parameter int PENW     = 8,
  parameter int RESET_PC = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctl_strobe_t     ctl,
  input  logic [PCW-1:0]  brTarget,
  input  logic [PCW-1:0]  seqPc,
  output logic [PCW-1:0]  fetchPc,
  output logic [PCW-1:0]  nextPc,
  output logic [PENW-1:0] lastPenalty
);

  localparam logic [PCW-1:0] PC_INIT = PCW'(RESET_PC);

  logic [PCW-1:0]  pcQ;
  logic [PCW-1:0]  savedTgtQ;
  logic [PCW-1:0]  fallPcQ;
  logic [PENW-1:0] penAccQ;
  logic [PENW-1:0] penQ;
  logic [PENW-1:0] killCnt;
  logic [PENW:0]   sumWide;
  logic [PENW-1:0] sumSat;

  always_comb begin
    killCnt = '0;
    for (int i = 0; i < KILL_W; i++) killCnt = killCnt + PENW'(ctl.killMask[i]);
  end

  assign sumWide = {1'b0, penAccQ} + {1'b0, killCnt};
  assign sumSat  = sumWide[PENW] ? '1 : sumWide[PENW-1:0];

  always_comb begin
    unique case (ctl.pcSel)
      PC_HOLD:      nextPc = pcQ;
      PC_TGT_NOW:   nextPc = brTarget;
      PC_TGT_SAVED: nextPc = savedTgtQ;
      PC_FALL:      nextPc = fallPcQ;
      default:      nextPc = seqPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ       <= PC_INIT;
      savedTgtQ <= '0;
      fallPcQ   <= '0;
      penAccQ   <= '0;
      penQ      <= '0;
    end else begin
      if (ctl.fetchEn) pcQ <= nextPc;
      if (ctl.capture) begin
        savedTgtQ <= brTarget;
        fallPcQ   <= pcQ;
        penAccQ   <= killCnt;
      end else if (ctl.tally) begin
        penAccQ <= sumSat;
      end
      if (ctl.commit) penQ <= sumSat;
    end
  end

  assign fetchPc     = pcQ;
  assign lastPenalty = penQ;

  // R2: with fetch stalled the fetch address must not move
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.fetchEn |=> (fetchPc == $past(fetchPc)));

  // R10: the published penalty only moves on a commit strobe
  p_penalty_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> $stable(lastPenalty));

endmodule

// File: rtl/branch_fetch_ctrl.sv
module branch_fetch_ctrl
  import bfc_pkg::*;
#(
  parameter int PCW      = 32,
  parameter int PENW     = 8,
  parameter int RESET_PC = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      policySel,
  input  logic            brDecoded,
  input  logic [PCW-1:0]  brTarget,
  input  logic            brResolved,
  input  logic            brTaken,
  input  logic [PCW-1:0]  seqPc,
  output logic [PCW-1:0]  fetchPc,
  output logic [PCW-1:0]  nextPc,
  output logic            fetchEn,
  output logic [2:0]      killMask,
  output logic            slotFault,
  output logic [1:0]      activePolicy,
  output logic [PENW-1:0] lastPenalty
);

  ctl_strobe_t ctl;
  logic        busy;

  bfc_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .policySel    (policySel),
    .brDecoded    (brDecoded),
    .brResolved   (brResolved),
    .brTaken      (brTaken),
    .ctl          (ctl),
    .slotFault    (slotFault),
    .busy         (busy),
    .activePolicy (activePolicy)
  );

  bfc_datapath #(
    .PCW      (PCW),
    .PENW     (PENW),
    .RESET_PC (RESET_PC)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .brTarget    (brTarget),
    .seqPc       (seqPc),
    .fetchPc     (fetchPc),
    .nextPc      (nextPc),
    .lastPenalty (lastPenalty)
  );

  assign fetchEn  = ctl.fetchEn;
  assign killMask = ctl.killMask;

  // R5: predict-taken fetches the decoded target in the following cycle
  p_taken_redirect_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && brDecoded && activePolicy == POL_TAKEN) |=> (fetchPc == $past(brTarget)));

  // R6: the delay-slot instruction in operand fetch is never killed
  p_delay_slot_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (activePolicy == POL_DELAYED) |-> !killMask[2]);

  // R9: the applied policy stays put while a branch is in flight
  p_policy_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (activePolicy == $past(activePolicy)));

  // R3: freeze keeps fetch stalled and the fetch slot empty until resolution
  p_freeze_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !brResolved && activePolicy == POL_FREEZE) |-> (!fetchEn && killMask == 3'b001));

  // R4: an untaken outcome under predict-untaken disturbs nothing
  p_untaken_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && brResolved && !brTaken && activePolicy == POL_UNTAKEN) |-> (killMask == 3'b000));

endmodule

// File: tb/branch_fetch_ctrl_bench.sv
module branch_fetch_ctrl_bench;

  localparam int PCW  = 16;
  localparam int PENW = 6;
  localparam int RPC  = 'h100;

  logic            clk;
  logic            rstN;
  logic [1:0]      policySel;
  logic            brDecoded;
  logic [PCW-1:0]  brTarget;
  logic            brResolved;
  logic            brTaken;
  logic [PCW-1:0]  seqPc;
  logic [PCW-1:0]  fetchPc;
  logic [PCW-1:0]  nextPc;
  logic            fetchEn;
  logic [2:0]      killMask;
  logic            slotFault;
  logic [1:0]      activePolicy;
  logic [PENW-1:0] lastPenalty;

  int checks = 0;
  int fails  = 0;
  logic [PENW-1:0] prevPen;

  branch_fetch_ctrl #(.PCW(PCW), .PENW(PENW), .RESET_PC(RPC)) u_branch_fetch_ctrl (
    .clk(clk), .rstN(rstN), .policySel(policySel), .brDecoded(brDecoded),
    .brTarget(brTarget), .brResolved(brResolved), .brTaken(brTaken), .seqPc(seqPc),
    .fetchPc(fetchPc), .nextPc(nextPc), .fetchEn(fetchEn), .killMask(killMask),
    .slotFault(slotFault), .activePolicy(activePolicy), .lastPenalty(lastPenalty)
  );

  assign seqPc = fetchPc + 16'd4;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic dec, input logic [PCW-1:0] tgt, input logic res,
                       input logic tk);
    @(negedge clk);
    brDecoded  = dec;
    brTarget   = tgt;
    brResolved = res;
    brTaken    = tk;
    #5;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic runBranch(input logic [1:0] pol, input logic tk, input logic [PCW-1:0] tgt);
    string req;
    logic [PCW-1:0] p0, eNextT, eNext2;
    logic [2:0] eKillT, eKill2;
    logic eFeT;
    logic [PENW-1:0] ePen;
    case (pol)
      2'd0: req = "R3";
      2'd1: req = "R4";
      2'd2: req = "R5";
      default: req = "R6";
    endcase
    policySel = pol;
    idle(2);
    check("R9", "policy latched when idle", 32'(activePolicy), 32'(pol));
    drive(1'b1, tgt, 1'b0, 1'b0);
    p0 = fetchPc;
    case (pol)
      2'd0: begin eKillT = 3'b001; eFeT = 1'b0; eNextT = p0;
                  eKill2 = 3'b001; eNext2 = tk ? tgt : p0; ePen = 6'd3; end
      2'd1: begin eKillT = 3'b000; eFeT = 1'b1; eNextT = p0 + 16'd4;
                  eKill2 = tk ? 3'b111 : 3'b000; eNext2 = tk ? tgt : p0 + 16'd12;
                  ePen = tk ? 6'd3 : 6'd0; end
      2'd2: begin eKillT = 3'b001; eFeT = 1'b1; eNextT = tgt;
                  eKill2 = tk ? 3'b000 : 3'b011; eNext2 = tk ? tgt + 16'd8 : p0;
                  ePen = tk ? 6'd1 : 6'd3; end
      default: begin eKillT = 3'b000; eFeT = 1'b1; eNextT = p0 + 16'd4;
                  eKill2 = tk ? 3'b011 : 3'b000; eNext2 = tk ? tgt : p0 + 16'd12;
                  ePen = tk ? 6'd2 : 6'd0; end
    endcase
    check("R10", "penalty held before resolve", 32'(lastPenalty), 32'(prevPen));
    check(req, "decode killMask", 32'(killMask), 32'(eKillT));
    check(req, "decode fetchEn", 32'(fetchEn), 32'(eFeT));
    if (eFeT) check(req, "decode nextPc", 32'(nextPc), 32'(eNextT));
    check("R7", "no slot fault at decode", 32'(slotFault), 32'(0));
    drive(1'b0, '0, 1'b0, 1'b0);
    check(req, "wait fetchEn", 32'(fetchEn), 32'(pol != 2'd0));
    check(req, "wait killMask", 32'(killMask), 32'((pol == 2'd0) ? 3'b001 : 3'b000));
    drive(1'b0, '0, 1'b1, tk);
    check(req, "resolve killMask", 32'(killMask), 32'(eKill2));
    check(req, "resolve nextPc", 32'(nextPc), 32'(eNext2));
    check(req, "resolve fetchEn", 32'(fetchEn), 32'(1));
    drive(1'b0, '0, 1'b0, 1'b0);
    check(req, "fetchPc after redirect", 32'(fetchPc), 32'(eNext2));
    check("R10", "penalty after resolve", 32'(lastPenalty), 32'(ePen));
    prevPen = ePen;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [PCW-1:0] a, p0, t1;
    logic [15:0] tgts [3];
    rstN = 1'b0; policySel = 2'd0; brDecoded = 1'b0; brTarget = '0;
    brResolved = 1'b0; brTaken = 1'b0; prevPen = '0;
    tgts[0] = 16'h2000; tgts[1] = 16'h0ff0; tgts[2] = 16'hfffc;
    repeat (3) @(negedge clk);
    #5;
    check("R1", "reset fetchPc", 32'(fetchPc), 32'(RPC));
    check("R1", "reset fetchEn", 32'(fetchEn), 32'(1));
    check("R1", "reset killMask", 32'(killMask), 32'(0));
    check("R1", "reset slotFault", 32'(slotFault), 32'(0));
    check("R1", "reset lastPenalty", 32'(lastPenalty), 32'(0));
    check("R1", "reset activePolicy", 32'(activePolicy), 32'(0));
    @(negedge clk);
    rstN = 1'b1;
    idle(1);
    a = fetchPc;
    check("R2", "idle nextPc", 32'(nextPc), 32'(a + 16'd4));
    check("R2", "idle killMask", 32'(killMask), 32'(0));
    idle(1);
    check("R2", "idle advance", 32'(fetchPc), 32'(a + 16'd4));

    for (int pol = 0; pol < 4; pol++)
      for (int tk = 0; tk < 2; tk++)
        for (int ti = 0; ti < 3; ti++)
          runBranch(2'(pol), 1'(tk), tgts[ti]);

    // R3: freeze resolving late costs one slot per cycle
    policySel = 2'd0;
    idle(2);
    drive(1'b1, 16'h4000, 1'b0, 1'b0);
    p0 = fetchPc;
    idle(3);
    check("R3", "late freeze still stalled", 32'(fetchEn), 32'(0));
    drive(1'b0, '0, 1'b1, 1'b0);
    check("R3", "late freeze nextPc", 32'(nextPc), 32'(p0));
    idle(1);
    check("R3", "late freeze fetchPc", 32'(fetchPc), 32'(p0));
    check("R3", "late freeze penalty", 32'(lastPenalty), 32'(5));

    // R7: branch in the delay slot
    policySel = 2'd3;
    idle(2);
    t1 = 16'h3000;
    drive(1'b1, t1, 1'b0, 1'b0);
    drive(1'b1, 16'h5000, 1'b0, 1'b0);
    check("R7", "slot fault raised", 32'(slotFault), 32'(1));
    drive(1'b0, '0, 1'b1, 1'b1);
    check("R7", "first target kept", 32'(nextPc), 32'(t1));
    check("R7", "slot fault cleared", 32'(slotFault), 32'(0));
    idle(1);
    check("R7", "fetch at first target", 32'(fetchPc), 32'(t1));

    // R8: second decode under predict-untaken ignored
    policySel = 2'd1;
    idle(2);
    drive(1'b1, 16'h6000, 1'b0, 1'b0);
    drive(1'b1, 16'h7000, 1'b0, 1'b0);
    check("R8", "no fault outside slot rule", 32'(slotFault), 32'(0));
    drive(1'b0, '0, 1'b1, 1'b1);
    check("R8", "redirect to first target", 32'(nextPc), 32'(16'h6000));
    idle(1);

    // R9: policy change in flight has no effect until idle
    policySel = 2'd1;
    idle(2);
    drive(1'b1, 16'h1230, 1'b0, 1'b0);
    policySel = 2'd0;
    drive(1'b0, '0, 1'b0, 1'b0);
    drive(1'b0, '0, 1'b1, 1'b1);
    check("R9", "policy unchanged in flight", 32'(activePolicy), 32'(1));
    check("R9", "old policy kill applied", 32'(killMask), 32'(3'b111));
    idle(1);
    idle(1);
    check("R9", "new policy after idle", 32'(activePolicy), 32'(0));

    // R11: stray resolution while idle
    prevPen = lastPenalty;
    drive(1'b0, '0, 1'b1, 1'b1);
    a = fetchPc;
    check("R11", "stray resolve killMask", 32'(killMask), 32'(0));
    check("R11", "stray resolve nextPc", 32'(nextPc), 32'(a + 16'd4));
    idle(1);
    check("R11", "stray resolve penalty", 32'(lastPenalty), 32'(prevPen));
    check("R11", "stray resolve fetchPc", 32'(fetchPc), 32'(a + 16'd4));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule